// File: doc/BRIEF.md
# Receive-Store-Replay Byte Controller

This block sits between a UART byte receiver, a dual-port byte memory and a UART byte transmitter. Each byte the receiver completes is written to the memory. Writes start at location zero and move to the next location after every byte. A debounced key pulse starts a replay, which reads the stored bytes back in address order and hands them one at a time to the transmitter. The next byte is fetched only after the transmitter reports that the current one has gone out.

The receiver places its byte on the bus one cycle before it raises its done strobe, so the byte is already stable when the write happens. The memory read port has registered output data. The block therefore holds the transmitter start back by the memory read latency, so the byte handed over is the one at the current read address.

Top module: `uart_store_replay`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the write address, the read address, the stored-byte count and the replay state all return to zero or idle. After that edge, `tx_go` and `mem_wr_en` are low and both memory addresses read 0.
- R2: In each cycle where `rx_done` is high, `mem_wr_addr` equals the number of bytes received since reset, modulo 256. The first write goes to address 0, and the address after 255 is 0.
- R3: `mem_wr_en` is high exactly in the cycles where `rx_done` is high. In that cycle `mem_wr_data` equals the `rx_byte` value presented the cycle before, including bytes with bit 7 and bit 6 set.
- R4: A `key_pulse` seen while idle, with at least one byte stored, starts a replay. The replay transmits the bytes at addresses 0 up to the last written address at the moment of the press, in increasing address order.
- R5: `tx_go` rises RD_LAT cycles after the read address is presented. At that cycle `tx_byte` equals the memory contents at the current read address, not at the previous one.
- R6: `tx_go` is a single-cycle pulse. A new `tx_go` is not raised until `tx_done` has followed the previous one, so no byte overlaps another at the transmitter.
- R7: A `key_pulse` received while a replay is running has no effect. The replay keeps its length and order, and no extra bytes follow it.
- R8: A `key_pulse` with no bytes stored starts nothing, and `tx_go` stays low.
- R9: Bytes received during a replay are written at the following write addresses. They do not change the running replay, and a later replay includes them.
- R10: The stored-byte count saturates at 256. After more than 256 writes, a replay sends all 256 locations in address order, with the wrapped locations holding the newest bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | DATA_W | Received byte, valid from one cycle before `rx_done` |
| rx_done | input | 1 | One-cycle pulse marking a completed received byte |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_wr_en | output | 1 | Memory write enable |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | DATA_W | Registered memory read data, RD_LAT cycles behind the address |
| key_pulse | input | 1 | One-cycle debounced key press |
| tx_go | output | 1 | One-cycle start pulse to the transmitter |
| tx_byte | output | DATA_W | Byte to transmit, valid while `tx_go` is high |
| tx_done | input | 1 | One-cycle pulse from the transmitter when a byte has been sent |

## Verification
The hardest situation to reach is a replay that is in progress while a second key press and new received bytes both arrive. A wrong design would then restart, lengthen the replay or shift its addresses. The stimulus forks a second key press and a burst of three receptions into the middle of a sixteen-byte replay. It checks that exactly the sixteen snapshot bytes come out, and then that a second replay shows nineteen. A final pass writes 260 bytes so the write address wraps and the count saturates, then replays all 256 locations against an arithmetic shadow of the memory.

// File: rtl/sr_pkg.sv
// Shared definitions for the receive-store-replay controller.
package sr_pkg;

    // Replay sequencer states
    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,   // waiting for a key press
        RP_ISSUE = 2'd1,   // read address presented, start the latency delay
        RP_ALIGN = 2'd2,   // waiting for memory data to arrive
        RP_SEND  = 2'd3    // byte handed to transmitter, waiting for done
    } rp_state_t;

endpackage

// File: rtl/sr_wr_seq.sv
// Write sequencer: every rx_done writes rx_byte at the running write pointer
// and advances it. It also keeps a saturating count of stored bytes.
// Assumes rx_byte is already stable in the cycle rx_done is high.
module sr_wr_seq #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_done,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en,
    output logic [ADDR_W:0]   fill
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(DEPTH);

    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W:0]   fill_q;

    // Purpose: advance the write pointer once per received byte (wraps)
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_ptr <= '0;
        else if (rx_done) wr_ptr <= wr_ptr + 1'b1;
    end

    // Purpose: count stored bytes, saturating at the memory depth
    always_ff @(posedge clk) begin
        if (!rst_n)                         fill_q <= '0;
        else if (rx_done && fill_q != FULL) fill_q <= fill_q + 1'b1;
    end

    // Purpose: write port driven straight from the receive interface
    always_comb begin
        wr_en   = rx_done;
        wr_data = rx_byte;
        wr_addr = wr_ptr;
    end

    assign fill = fill_q;

    AST_WR_PTR_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !rx_done |=> $stable(wr_ptr)); // R2
    AST_PTR_MATCH_FILL: assert property (@(posedge clk) disable iff (!rst_n) (fill_q != FULL) |-> (wr_ptr == fill_q[ADDR_W-1:0])); // R2
    AST_FILL_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) fill_q <= FULL); // R10
endmodule

// File: rtl/sr_lat_align.sv
// Latency aligner: delays the issue pulse by the memory read latency so the
// transmitter start coincides with valid read data. LAT = 0 passes through.
module sr_lat_align #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic go
);
    generate
        if (LAT == 0) begin : g_pass
            assign go = issue;
        end else begin : g_pipe
            logic [LAT-1:0] stage;
            // Purpose: shift the issue pulse through LAT register stages
            always_ff @(posedge clk) begin
                if (!rst_n) stage <= '0;
                else begin
                    stage[0] <= issue;
                    for (int i = 1; i < LAT; i++) stage[i] <= stage[i-1];
                end
            end
            assign go = stage[LAT-1];
        end
    endgenerate

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) go |=> !go); // R6
endmodule

// File: rtl/sr_replay_ctl.sv
// Replay sequencer: on a key press while idle and non-empty, snapshots the
// last written address and walks the read address from 0 to it. Each byte
// is issued, aligned to read latency, then held until tx_done.
// Assumes tx_done arrives only after the go it answers.
module sr_replay_ctl
    import sr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_pulse,
    input  logic [ADDR_W:0]   fill,
    input  logic              go,
    input  logic              tx_done,
    output logic              issue,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy
);
    rp_state_t         state;
    logic [ADDR_W-1:0] last;
    logic [ADDR_W:0]   fill_m1;

    assign fill_m1 = fill - 1'b1;

    // Purpose: replay state machine with read address and end snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RP_IDLE;
            rd_addr <= '0;
            last    <= '0;
        end else begin
            case (state)
                RP_IDLE: if (key_pulse && fill != '0) begin
                    last    <= fill_m1[ADDR_W-1:0];
                    rd_addr <= '0;
                    state   <= RP_ISSUE;
                end
                RP_ISSUE: state <= go ? RP_SEND : RP_ALIGN;
                RP_ALIGN: if (go) state <= RP_SEND;
                RP_SEND: if (tx_done) begin
                    if (rd_addr == last) state <= RP_IDLE;
                    else begin
                        rd_addr <= rd_addr + 1'b1;
                        state   <= RP_ISSUE;
                    end
                end
                default: state <= RP_IDLE;
            endcase
        end
    end

    // Purpose: decode outputs from state
    always_comb begin
        issue = (state == RP_ISSUE);
        busy  = (state != RP_IDLE);
    end

    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (rd_addr <= last)); // R4
    AST_GO_ALIGNED:  assert property (@(posedge clk) disable iff (!rst_n) go |-> (state == RP_ALIGN || state == RP_ISSUE)); // R5
    AST_RD_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (state == RP_SEND && !tx_done) |=> $stable(rd_addr)); // R6
    AST_KEY_BUSY:    assert property (@(posedge clk) disable iff (!rst_n) (busy && key_pulse) |=> $stable(last)); // R7
    AST_EMPTY_IDLE:  assert property (@(posedge clk) disable iff (!rst_n) (state == RP_IDLE && fill == '0) |=> state == RP_IDLE); // R8
endmodule

// File: rtl/uart_store_replay.sv
// Top: stores received bytes in a dual-port memory and replays them to a
// transmitter on a key press. Assumes a registered read port of RD_LAT
// cycles, a receiver whose byte leads its done strobe, and a debounced key.
module uart_store_replay #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_done,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              key_pulse,
    output logic              tx_go,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_done
);
    logic [ADDR_W:0] fill;
    logic            issue;
    logic            go;
    logic            busy;

    sr_wr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_byte (rx_byte),
        .rx_done (rx_done),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data),
        .wr_en   (mem_wr_en),
        .fill    (fill)
    );

    sr_replay_ctl #(.ADDR_W(ADDR_W)) u_rp (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_pulse (key_pulse),
        .fill      (fill),
        .go        (go),
        .tx_done   (tx_done),
        .issue     (issue),
        .rd_addr   (mem_rd_addr),
        .busy      (busy)
    );

    sr_lat_align #(.LAT(RD_LAT)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue),
        .go    (go)
    );

    // Purpose: transmitter handshake fed from aligned read data
    always_comb begin
        tx_go   = go;
        tx_byte = mem_rd_data;
    end

    AST_GO_NEEDS_REPLAY: assert property (@(posedge clk) disable iff (!rst_n) tx_go |-> busy); // R4
endmodule

// File: tb/tb_uart_store_replay.sv
`timescale 1ns/100ps
module tb_uart_store_replay;
    localparam int AW = 8, DW = 8, DEPTH = 256, TX_CYC = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [DW-1:0] rx_byte = '0;
    logic          rx_done = 1'b0;
    logic [AW-1:0] mem_wr_addr, mem_rd_addr;
    logic [DW-1:0] mem_wr_data, mem_rd_data, tx_byte;
    logic          mem_wr_en, tx_go;
    logic          key_pulse = 1'b0;
    logic          tx_done = 1'b0;

    uart_store_replay #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(1)) dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_done(rx_done),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_en(mem_wr_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .key_pulse(key_pulse),
        .tx_go(tx_go), .tx_byte(tx_byte), .tx_done(tx_done)
    );

    // Memory model: one-cycle registered read
    logic [DW-1:0] mem_m [DEPTH];
    initial for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    always @(posedge clk) begin
        if (mem_wr_en) mem_m[mem_wr_addr] <= mem_wr_data;
        mem_rd_data <= mem_m[mem_rd_addr];
    end

    // Transmitter model: records bytes, answers with tx_done after TX_CYC
    logic       tx_busy = 1'b0;
    int         tx_cnt = 0, rec_n = 0, overlap = 0;
    logic [7:0] rec [512];
    always @(posedge clk) begin
        tx_done <= 1'b0;
        if (tx_busy) begin
            if (tx_cnt == 1) begin tx_busy <= 1'b0; tx_done <= 1'b1; end
            tx_cnt <= tx_cnt - 1;
        end
        if (tx_go) begin
            if (tx_busy) overlap <= overlap + 1;
            else begin
                tx_busy <= 1'b1; tx_cnt <= TX_CYC;
                rec[rec_n] <= tx_byte; rec_n <= rec_n + 1;
            end
        end
    end

    int vectors = 0, miscompares = 0;
    logic [7:0] shadow [DEPTH];
    logic [7:0] expq [DEPTH];
    int exp_wr = 0, stored = 0, go_seen = 0;
    bit done_flag = 0;
    always @(posedge clk) if (tx_go) go_seen <= go_seen + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_go == 0 && mem_wr_en == 0, "R1 go/wr low", {tx_go, mem_wr_en}, 0);
        chk(mem_wr_addr == 0, "R1 wr addr", mem_wr_addr, 0);
        chk(mem_rd_addr == 0, "R1 rd addr", mem_rd_addr, 0);
        rst_n = 1'b1;
        exp_wr = 0; stored = 0;
    endtask

    task automatic send_rx(input logic [7:0] v);
        @(negedge clk) rx_byte = v;
        @(negedge clk) rx_done = 1'b1;
        #0.5;
        chk(mem_wr_en == 1'b1, "R3 write enable", mem_wr_en, 1);
        chk(mem_wr_addr == exp_wr[7:0], "R2 write address", mem_wr_addr, exp_wr);
        chk(mem_wr_data == v, "R3 write data", mem_wr_data, v);
        shadow[exp_wr] = v;
        exp_wr = (exp_wr + 1) % DEPTH;
        if (stored < DEPTH) stored++;
        @(negedge clk) rx_done = 1'b0; rx_byte = ~v;
        #0.5;
        chk(mem_wr_en == 1'b0, "R3 no write without done", mem_wr_en, 0);
    endtask

    task automatic press_key();
        @(negedge clk) key_pulse = 1'b1;
        @(negedge clk) key_pulse = 1'b0;
    endtask

    task automatic snapshot(output int n);
        n = stored;
        for (int i = 0; i < DEPTH; i++) expq[i] = shadow[i];
    endtask

    task automatic wait_and_compare(input int base, input int n, input string req);
        for (int c = 0; c < 40000; c++) begin
            @(negedge clk);
            if (rec_n - base >= n) break;
        end
        repeat (60) @(negedge clk);
        chk(rec_n - base == n, {req, " byte count"}, rec_n - base, n);
        for (int i = 0; i < n; i++)
            chk(rec[base+i] == expq[i], {req, " byte order/value"}, rec[base+i], expq[i]);
        chk(overlap == 0, "R6 no overlapping go", overlap, 0);
    endtask

    initial begin
        int n, base, g0;
        do_reset();

        // R8: key with nothing stored
        g0 = go_seen;
        press_key();
        repeat (50) @(negedge clk);
        chk(go_seen == g0, "R8 empty key ignored", go_seen - g0, 0);

        // R2/R3: sixteen bytes, many with the two top bits set
        for (int k = 0; k < 16; k++) send_rx(8'((k * 73 + 8'hC1) & 8'hFF));
        snapshot(n);
        base = rec_n;
        press_key();
        // R7 + R9: key again and new receptions mid-replay
        fork
            begin repeat (30) @(negedge clk); press_key(); end
            begin repeat (20) @(negedge clk);
                  send_rx(8'hF1); send_rx(8'hC0); send_rx(8'h7E); end
        join
        wait_and_compare(base, n, "R4 R5 R7 R9 first replay");

        // R9: a later replay includes bytes written during the first one
        snapshot(n);
        chk(n == 19, "R9 stored count", n, 19);
        base = rec_n;
        press_key();
        wait_and_compare(base, n, "R9 second replay");

        // R10: wrap the write address and saturate the count
        do_reset();
        for (int k = 0; k < 260; k++) send_rx(8'((k * 29 + 8'hC0) & 8'hFF));
        snapshot(n);
        chk(n == DEPTH, "R10 saturated count", n, DEPTH);
        base = rec_n;
        press_key();
        wait_and_compare(base, n, "R10 R5 full replay");

        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            done_flag = 1;
            vectors++; miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule